// File: doc/BRIEF.md
# Video DAC Output Channel Router

This block sits between the video encoders of a display chip and its six digital-to-analog converters. It takes pixel samples from three producers. The primary standard-definition encoder supplies composite, luma, chroma, and the three component channels. The high-definition path supplies three colour lanes. The secondary encoder supplies composite, luma and chroma. The block picks one word for each converter on every pixel clock.

Converters one to four serve the primary pipeline and five and six serve the secondary one. Each converter has its own selection rule. The rule depends on three enable bits in a converter control register, and on a standard/high-definition mode bit and a colour-space bit in an input control register. Software writes both registers through a small write port. Some converters are wired to a fixed source. A chroma enable left set while high-definition mode is active is treated as an illegal setting. It raises a sticky error flag and the high-definition mapping is used anyway.

Top module: `video_dac_router`

## Requirements
- R1: After reset every converter output is 0 and `cfg_err` is 0. The registers hold SD mode (input-control bit 0 = 1), RGB colour space (input-control bit 1 = 1), and composite, chroma and luma enables set (converter-control bits 0, 1, 2 = 1).
- R2: `dac1` carries `sd_cvbs` when the composite enable (converter-control bit 0) is 1, and `sd_y` when it is 0, in either mode.
- R3: In SD mode, `dac2` carries `sd_c` when the chroma enable (converter-control bit 1) is 1, and `sd_rv` when it is 0.
- R4: In HD mode (input-control bit 0 = 0), `dac2` carries `hd_lane2` in RGB mode and `hd_lane0` in YUV mode. The HD lanes hold G,B,R in RGB and Y,U,V in YUV.
- R5: In SD mode, `dac3` carries `sd_y` when the luma enable (converter-control bit 2) is 1, and `sd_gy` when it is 0.
- R6: In HD mode, `dac3` carries `hd_lane0` in RGB mode and `hd_lane1` in YUV mode.
- R7: `dac4` has no enable. It carries `sd_bu` in SD mode. In HD mode it carries `hd_lane1` in RGB and `hd_lane2` in YUV.
- R8: `dac5` carries `sec_cvbs` when the composite enable is 1, and `sec_y` when it is 0.
- R9: `dac6` always carries `sec_c`.
- R10: When HD mode and the chroma enable are both active, `cfg_err` goes to 1 at that edge and stays 1 until reset. `dac2` still follows R4.
- R11: Each output equals its selected input sampled at the previous clock edge. A write accepted at an edge already governs the outputs registered at that same edge. Writes to any address other than 0x2D (converter control) or 0x3A (input control) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 3 | Register write data |
| sd_cvbs | input | DATA_W | Primary SD composite |
| sd_y | input | DATA_W | Primary SD luma |
| sd_c | input | DATA_W | Primary SD chroma |
| sd_rv | input | DATA_W | Primary SD red / V component |
| sd_gy | input | DATA_W | Primary SD green / Y component |
| sd_bu | input | DATA_W | Primary SD blue / U component |
| hd_lane0 | input | DATA_W | HD lane 0 (G or Y) |
| hd_lane1 | input | DATA_W | HD lane 1 (B or U) |
| hd_lane2 | input | DATA_W | HD lane 2 (R or V) |
| sec_cvbs | input | DATA_W | Secondary composite |
| sec_y | input | DATA_W | Secondary luma |
| sec_c | input | DATA_W | Secondary chroma |
| dac1 | output | DATA_W | Converter 1 word |
| dac2 | output | DATA_W | Converter 2 word |
| dac3 | output | DATA_W | Converter 3 word |
| dac4 | output | DATA_W | Converter 4 word |
| dac5 | output | DATA_W | Converter 5 word |
| dac6 | output | DATA_W | Converter 6 word |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The hardest case to reach is the illegal HD-with-chroma setting. It needs two writes in the right order, and then the flag must be shown to stay set after the setting has been made legal again. A directed sequence reaches that state, clears the chroma enable, and then checks both the flag and the converter 2 word. The random phase mixes writes to both registers and to stray addresses with random samples on every input. It covers each mode and colour-space pair at the edge where the write lands.

// File: rtl/dacr_pkg.sv
package dacr_pkg;

    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned REG_DW    = 3;
    localparam logic [ADDR_W-1:0] CTL_ADDR = 8'h2D;
    localparam logic [ADDR_W-1:0] INP_ADDR = 8'h3A;

    // bit positions inside the two registers
    localparam int unsigned CTL_CVBS_BIT = 0;
    localparam int unsigned CTL_C_BIT    = 1;
    localparam int unsigned CTL_Y_BIT    = 2;
    localparam int unsigned INP_SD_BIT   = 0;
    localparam int unsigned INP_RGB_BIT  = 1;

    typedef struct packed {
        logic cvbs_en;
        logic chroma_en;
        logic luma_en;
        logic sd_mode;
        logic hd_rgb;
    } dacr_cfg_t;

    localparam dacr_cfg_t CFG_RESET = '{
        cvbs_en: 1'b1, chroma_en: 1'b1, luma_en: 1'b1,
        sd_mode: 1'b1, hd_rgb: 1'b1
    };

endpackage

// File: rtl/dacr_regdec.sv
module dacr_regdec
    import dacr_pkg::*;
(
    input  dacr_cfg_t                cfg_q,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [REG_DW-1:0]        wr_data,
    output dacr_cfg_t                cfg_d
);
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == CTL_ADDR) begin
                cfg_d.cvbs_en   = wr_data[CTL_CVBS_BIT];
                cfg_d.chroma_en = wr_data[CTL_C_BIT];
                cfg_d.luma_en   = wr_data[CTL_Y_BIT];
            end else if (wr_addr == INP_ADDR) begin
                cfg_d.sd_mode   = wr_data[INP_SD_BIT];
                cfg_d.hd_rgb    = wr_data[INP_RGB_BIT];
            end
        end
    end
endmodule

// File: rtl/dacr_route.sv
module dacr_route
    import dacr_pkg::*;
#(
    parameter int unsigned DATA_W = 10
) (
    input  dacr_cfg_t          cfg,
    input  logic [DATA_W-1:0]  sd_cvbs,
    input  logic [DATA_W-1:0]  sd_y,
    input  logic [DATA_W-1:0]  sd_c,
    input  logic [DATA_W-1:0]  sd_rv,
    input  logic [DATA_W-1:0]  sd_gy,
    input  logic [DATA_W-1:0]  sd_bu,
    input  logic [DATA_W-1:0]  hd_lane0,
    input  logic [DATA_W-1:0]  hd_lane1,
    input  logic [DATA_W-1:0]  hd_lane2,
    input  logic [DATA_W-1:0]  sec_cvbs,
    input  logic [DATA_W-1:0]  sec_y,
    input  logic [DATA_W-1:0]  sec_c,
    output logic [DATA_W-1:0]  o1,
    output logic [DATA_W-1:0]  o2,
    output logic [DATA_W-1:0]  o3,
    output logic [DATA_W-1:0]  o4,
    output logic [DATA_W-1:0]  o5,
    output logic [DATA_W-1:0]  o6,
    output logic               conflict
);
    always_comb begin
        // converter 1 and 5 share the composite enable
        o1 = cfg.cvbs_en ? sd_cvbs  : sd_y;
        o5 = cfg.cvbs_en ? sec_cvbs : sec_y;
        o6 = sec_c;
        if (cfg.sd_mode) begin
            o2 = cfg.chroma_en ? sd_c : sd_rv;
            o3 = cfg.luma_en   ? sd_y : sd_gy;
            o4 = sd_bu;
        end else if (cfg.hd_rgb) begin
            // lanes hold G,B,R
            o2 = hd_lane2;
            o3 = hd_lane0;
            o4 = hd_lane1;
        end else begin
            // lanes hold Y,U,V
            o2 = hd_lane0;
            o3 = hd_lane1;
            o4 = hd_lane2;
        end
        conflict = !cfg.sd_mode && cfg.chroma_en;
    end
endmodule

// File: rtl/video_dac_router.sv
module video_dac_router
    import dacr_pkg::*;
#(
    parameter int unsigned DATA_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          wr_addr,
    input  logic [2:0]          wr_data,
    input  logic [DATA_W-1:0]   sd_cvbs,
    input  logic [DATA_W-1:0]   sd_y,
    input  logic [DATA_W-1:0]   sd_c,
    input  logic [DATA_W-1:0]   sd_rv,
    input  logic [DATA_W-1:0]   sd_gy,
    input  logic [DATA_W-1:0]   sd_bu,
    input  logic [DATA_W-1:0]   hd_lane0,
    input  logic [DATA_W-1:0]   hd_lane1,
    input  logic [DATA_W-1:0]   hd_lane2,
    input  logic [DATA_W-1:0]   sec_cvbs,
    input  logic [DATA_W-1:0]   sec_y,
    input  logic [DATA_W-1:0]   sec_c,
    output logic [DATA_W-1:0]   dac1,
    output logic [DATA_W-1:0]   dac2,
    output logic [DATA_W-1:0]   dac3,
    output logic [DATA_W-1:0]   dac4,
    output logic [DATA_W-1:0]   dac5,
    output logic [DATA_W-1:0]   dac6,
    output logic                cfg_err
);
    localparam int unsigned NUM_DAC = 6;

    typedef struct packed {
        dacr_cfg_t                          cfg;
        logic [NUM_DAC-1:0][DATA_W-1:0]     dac;
        logic                               err;
    } state_t;

    state_t    st_d, st_q;
    dacr_cfg_t cfg_q, cfg_next;
    logic [NUM_DAC-1:0][DATA_W-1:0] route_w;
    logic      conflict_w;

    assign cfg_q = st_q.cfg;

    dacr_regdec u_regdec (
        .cfg_q   (cfg_q),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_d   (cfg_next)
    );

    dacr_route #(.DATA_W(DATA_W)) u_route (
        .cfg      (cfg_next),
        .sd_cvbs  (sd_cvbs),
        .sd_y     (sd_y),
        .sd_c     (sd_c),
        .sd_rv    (sd_rv),
        .sd_gy    (sd_gy),
        .sd_bu    (sd_bu),
        .hd_lane0 (hd_lane0),
        .hd_lane1 (hd_lane1),
        .hd_lane2 (hd_lane2),
        .sec_cvbs (sec_cvbs),
        .sec_y    (sec_y),
        .sec_c    (sec_c),
        .o1       (route_w[0]),
        .o2       (route_w[1]),
        .o3       (route_w[2]),
        .o4       (route_w[3]),
        .o5       (route_w[4]),
        .o6       (route_w[5]),
        .conflict (conflict_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cfg = cfg_next;
        st_d.err = st_q.err | conflict_w;
        for (int i = 0; i < NUM_DAC; i++) begin
            st_d.dac[i] = route_w[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= CFG_RESET;
            st_q.dac <= '0;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac1    = st_q.dac[0];
    assign dac2    = st_q.dac[1];
    assign dac3    = st_q.dac[2];
    assign dac4    = st_q.dac[3];
    assign dac5    = st_q.dac[4];
    assign dac6    = st_q.dac[5];
    assign cfg_err = st_q.err;
endmodule

// File: rtl/video_dac_router_chk.sv
module video_dac_router_chk
    import dacr_pkg::*;
#(
    parameter int unsigned DATA_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  dacr_cfg_t          cfg_q,
    input  logic [DATA_W-1:0]  sd_cvbs,
    input  logic [DATA_W-1:0]  sd_bu,
    input  logic [DATA_W-1:0]  sec_c,
    input  logic [DATA_W-1:0]  dac1,
    input  logic [DATA_W-1:0]  dac4,
    input  logic [DATA_W-1:0]  dac6,
    input  logic               cfg_err
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (cfg_err == 1'b0 && dac6 == '0);
        end
    end

    // R9
    sec_chroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> dac6 == $past(sec_c));

    // R2
    cvbs_out1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && cfg_q.cvbs_en) |-> dac1 == $past(sd_cvbs));

    // R7
    sd_blue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && cfg_q.sd_mode) |-> dac4 == $past(sd_bu));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(cfg_err)) |-> cfg_err);

    // R10
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.sd_mode && cfg_q.chroma_en) |-> cfg_err);
endmodule

bind video_dac_router video_dac_router_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_q   (cfg_q),
    .sd_cvbs (sd_cvbs),
    .sd_bu   (sd_bu),
    .sec_c   (sec_c),
    .dac1    (dac1),
    .dac4    (dac4),
    .dac6    (dac6),
    .cfg_err (cfg_err)
);

// File: tb/video_dac_router_tb_top.sv
module video_dac_router_tb_top;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [2:0] wr_data = '0;
    logic [W-1:0] s_cvbs = '0, s_y = '0, s_c = '0, s_rv = '0, s_gy = '0, s_bu = '0;
    logic [W-1:0] h0 = '0, h1 = '0, h2 = '0, x_cvbs = '0, x_y = '0, x_c = '0;
    logic [W-1:0] dac1, dac2, dac3, dac4, dac5, dac6;
    logic cfg_err;

    int n_cmp = 0;
    int n_bad = 0;

    // model state: ctl bit0 cvbs, bit1 chroma, bit2 luma; inp bit0 sd, bit1 rgb
    logic [2:0] m_ctl;
    logic [1:0] m_inp;
    logic       m_err;

    always #2 clk = ~clk;

    video_dac_router #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sd_cvbs(s_cvbs), .sd_y(s_y), .sd_c(s_c), .sd_rv(s_rv), .sd_gy(s_gy), .sd_bu(s_bu),
        .hd_lane0(h0), .hd_lane1(h1), .hd_lane2(h2),
        .sec_cvbs(x_cvbs), .sec_y(x_y), .sec_c(x_c),
        .dac1(dac1), .dac2(dac2), .dac3(dac3), .dac4(dac4), .dac5(dac5), .dac6(dac6),
        .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] exp_o2();
        if (m_inp[0]) return m_ctl[1] ? s_c : s_rv;   // R3
        return m_inp[1] ? h2 : h0;                    // R4
    endfunction
    function automatic logic [W-1:0] exp_o3();
        if (m_inp[0]) return m_ctl[2] ? s_y : s_gy;   // R5
        return m_inp[1] ? h0 : h1;                    // R6
    endfunction
    function automatic logic [W-1:0] exp_o4();
        if (m_inp[0]) return s_bu;                    // R7
        return m_inp[1] ? h1 : h2;
    endfunction

    task automatic check_all(input string tag);
        check({tag, " R2 dac1"}, dac1, m_ctl[0] ? s_cvbs : s_y);
        check({tag, m_inp[0] ? " R3 dac2" : " R4 dac2"}, dac2, exp_o2());
        check({tag, m_inp[0] ? " R5 dac3" : " R6 dac3"}, dac3, exp_o3());
        check({tag, " R7 dac4"}, dac4, exp_o4());
        check({tag, " R8 dac5"}, dac5, m_ctl[0] ? x_cvbs : x_y);
        check({tag, " R9 dac6"}, dac6, x_c);
        check({tag, " R10 cfg_err"}, {{(W-1){1'b0}}, cfg_err}, {{(W-1){1'b0}}, m_err});
    endtask

    // one pixel cycle: drive at negedge, model updates at posedge, compare after it (R11)
    task automatic cyc(input logic we, input logic [7:0] a, input logic [2:0] d, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        s_cvbs = W'($urandom); s_y = W'($urandom); s_c = W'($urandom);
        s_rv = W'($urandom); s_gy = W'($urandom); s_bu = W'($urandom);
        h0 = W'($urandom); h1 = W'($urandom); h2 = W'($urandom);
        x_cvbs = W'($urandom); x_y = W'($urandom); x_c = W'($urandom);
        @(posedge clk);
        if (we && a == 8'h2D) m_ctl = d;
        else if (we && a == 8'h3A) m_inp = d[1:0];
        if (!m_inp[0] && m_ctl[1]) m_err = 1'b1;
        #1;
        check_all(tag);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        process::self().srandom(32'd1234);
        m_ctl = 3'b111; m_inp = 2'b11; m_err = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 dac1 reset", dac1, '0);
        check("R1 dac6 reset", dac6, '0);
        check("R1 cfg_err reset", {{(W-1){1'b0}}, cfg_err}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 register reset values shown by routing with no writes
        cyc(1'b0, 8'h00, 3'b000, "R1 default");
        // R2 R3 R5 R8 SD enables off
        cyc(1'b1, 8'h2D, 3'b000, "R11 write-at-edge");
        cyc(1'b0, 8'h00, 3'b000, "SD all off");
        cyc(1'b1, 8'h2D, 3'b101, "SD cvbs+luma");
        // R11 stray address ignored
        cyc(1'b1, 8'h2E, 3'b010, "R11 stray addr");
        cyc(1'b1, 8'h3B, 3'b000, "R11 stray addr");
        // R4 R6 HD RGB and YUV with chroma off (legal)
        cyc(1'b1, 8'h3A, 3'b010, "HD RGB");
        cyc(1'b1, 8'h3A, 3'b000, "HD YUV");
        cyc(1'b0, 8'h00, 3'b000, "HD YUV hold");
        // R10 illegal: chroma on in HD, then cleared; flag stays
        cyc(1'b1, 8'h2D, 3'b011, "R10 conflict");
        cyc(1'b1, 8'h2D, 3'b001, "R10 cleared");
        cyc(1'b1, 8'h3A, 3'b011, "R10 back to SD");
        // reset again and start random from a clean flag
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 cfg_err after reset", {{(W-1){1'b0}}, cfg_err}, '0);
        check("R1 dac2 after reset", dac2, '0);
        m_ctl = 3'b111; m_inp = 2'b11; m_err = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 7);
            logic [7:0] a;
            a = (sel < 3) ? 8'h2D : (sel < 6) ? 8'h3A : 8'($urandom);
            cyc($urandom_range(0, 3) == 0, a, 3'($urandom), "random");
        end
        finish_run();
    end
endmodule